// File: doc/BRIEF.md
# SMM Access Controller

This block decides whether a memory access that lands in one of three system-management windows may reach DRAM, and where it goes. The windows are the compatible window (000A_0000h to 000B_FFFFh), a high alias window (FEDA_0000h to FEDB_FFFFh) that is folded back onto the compatible DRAM area, and a 1 MB protected segment placed directly under the graphics stolen-memory base. Each request carries the address, whether the processor is in system-management mode, whether it is a code fetch or a data access, and whether it came from the processor or from the downstream interface.

A 7-bit control word sets the policy. It holds a global enable, one enable per window, an open override, a close override and a lock. The open override lets ordinary software reach the windows as if it were in system-management mode. The close override sends data accesses in the compatible window to the video/I/O path, so the display stays reachable. Setting the lock freezes the whole word until reset. Each answer carries four things: a grant to DRAM, the DRAM address, a route-to-I/O flag and an error flag. An access outside every enabled window passes through untouched.

Each request runs through a three-state machine. In ST_IDLE, req_ready is high and a request with req_valid high is captured, together with a snapshot of the policy, and the machine moves to ST_CLASSIFY. In ST_CLASSIFY the window hit and the remapped address are registered, and the machine moves on to ST_RESPOND without condition. In ST_RESPOND the decision is registered onto the outputs, and the machine goes back to ST_IDLE without condition. In ST_IDLE with no request, the machine stays in ST_IDLE.

Top module: `smm_access_ctl`

## Requirements
- R1: After reset the control word reads 0, req_ready is 1 and rsp_valid is 0.
- R2: A request accepted at a clock edge (req_valid and req_ready both high) gives rsp_valid high for exactly one cycle, after the second following edge. req_ready is low from acceptance until the response, and grant, route and error are all 0 whenever rsp_valid is 0.
- R3: With the global enable (control bit 0) clear, every access is granted with its address unchanged, with no route to I/O and no error, even inside a window.
- R4: With the global enable and the compatible enable (bit 1) set, an SMM-mode processor access to 000A_0000h to 000B_FFFFh is granted at the same address.
- R5: A processor access that hits an enabled window without SMM rights is not granted and is routed to I/O. A response routed to I/O is never granted.
- R6: The open bit (bit 4) gives non-SMM processor accesses the same rights as SMM-mode accesses.
- R7: With the close bit (bit 5) set, SMM-mode data accesses to the compatible window are routed to I/O, while code fetches are still granted. The close bit has no effect on the high window or the protected segment.
- R8: When open and close are both set, every response carries the error flag, and the open bit is ignored while the close behaviour applies.
- R9: A downstream-interface access that hits an enabled window is not granted, is not routed to I/O, and raises the error flag for its one response cycle.
- R10: With the high enable (bit 2) set, an access with SMM rights to FEDA_0000h to FEDB_FFFFh is granted at address − FEDA_0000h + 000A_0000h. With the high enable clear, such an access passes through unchanged.
- R11: With the segment enable (bit 3) set and a non-zero stolen base B (in MB units), the protected segment covers the 1 MB whose address bits [31:20] equal B−1. When B is 0, no segment exists.
- R12: Once the lock bit (bit 6) is set, control writes are ignored until reset. The frozen policy keeps working.
- R13: An address outside every window is granted unchanged, whatever the policy and the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word write data |
| ctl_q | output | 7 | Current control word |
| gfx_base_mb | input | 12 | Graphics stolen-memory base, MB units |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request address |
| req_smm | input | 1 | Processor is in system-management mode |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_downstream | input | 1 | Request came from the downstream interface |
| rsp_valid | output | 1 | Decision valid (one cycle) |
| rsp_grant | output | 1 | Access may reach DRAM |
| rsp_to_io | output | 1 | Access goes to the video/I/O path |
| rsp_err | output | 1 | Denied downstream access or override conflict |
| rsp_addr | output | 32 | DRAM address (remapped for the high window) |

## Verification
The assertions check the response timing on every cycle. They check that rsp_valid lasts one cycle, that req_ready drops after acceptance, and that the outputs stay quiet outside a response. They also check that the control word stays frozen once locked and that an I/O-routed response is never granted. Only the bench scenarios can show the routing decisions themselves. These include the open and close overrides and their conflict, the high-window remap arithmetic, the segment placement relative to the stolen base (including a zero base), and the denial of downstream accesses.

// File: rtl/smm_pkg.sv
`timescale 1ns/1ps
package smm_pkg;

    typedef struct packed {
        logic lock;
        logic close_d;
        logic open_d;
        logic tseg_en;
        logic high_en;
        logic compat_en;
        logic global_en;
    } smm_ctl_t;

    localparam int CTL_W    = $bits(smm_ctl_t);
    localparam int LOCK_POS = CTL_W - 1;
    localparam int MB_SHIFT = 20;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_COMPAT,
        WIN_HIGH,
        WIN_TSEG
    } smm_win_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_RESPOND
    } smm_state_e;

    localparam logic [31:0] COMPAT_LO = 32'h000A_0000;
    localparam logic [31:0] COMPAT_HI = 32'h000B_FFFF;
    localparam logic [31:0] HIGH_LO   = 32'hFEDA_0000;
    localparam logic [31:0] HIGH_HI   = 32'hFEDB_FFFF;

endpackage

// File: rtl/smm_ctl_reg.sv
`timescale 1ns/1ps
module smm_ctl_reg
    import smm_pkg::*;
#(
    parameter int W    = CTL_W,
    parameter int LOCK = LOCK_POS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctl
);

    logic frozen;
    assign frozen = ctl[LOCK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_en && !frozen) begin
            ctl <= wr_data;
        end
    end

endmodule

// File: rtl/smm_window_decode.sv
`timescale 1ns/1ps
module smm_window_decode
    import smm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MB_W   = ADDR_W - MB_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_global,
    input  logic              en_compat,
    input  logic              en_high,
    input  logic              en_tseg,
    input  logic [MB_W-1:0]   base_mb,
    output smm_win_e          win,
    output logic [ADDR_W-1:0] remap
);

    localparam logic [ADDR_W-1:0] C_LO = ADDR_W'(COMPAT_LO);
    localparam logic [ADDR_W-1:0] C_HI = ADDR_W'(COMPAT_HI);
    localparam logic [ADDR_W-1:0] H_LO = ADDR_W'(HIGH_LO);
    localparam logic [ADDR_W-1:0] H_HI = ADDR_W'(HIGH_HI);

    logic            in_compat;
    logic            in_high;
    logic            in_tseg;
    logic [MB_W-1:0] tseg_mb;

    assign tseg_mb   = base_mb - MB_W'(1);
    assign in_compat = (addr >= C_LO) && (addr <= C_HI);
    assign in_high   = (addr >= H_LO) && (addr <= H_HI);
    assign in_tseg   = (base_mb != '0) && (addr[ADDR_W-1:MB_SHIFT] == tseg_mb);

    // Alias window folds onto the compatible DRAM area
    assign remap = addr - H_LO + C_LO;

    // Priority: compatible, then high alias, then protected segment
    always_comb begin
        win = WIN_NONE;
        if (en_global) begin
            if (en_compat && in_compat) begin
                win = WIN_COMPAT;
            end else if (en_high && in_high) begin
                win = WIN_HIGH;
            end else if (en_tseg && in_tseg) begin
                win = WIN_TSEG;
            end
        end
    end

endmodule

// File: rtl/smm_policy.sv
`timescale 1ns/1ps
module smm_policy
    import smm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  smm_win_e          win,
    input  logic              ov_open,
    input  logic              ov_close,
    input  logic              smm,
    input  logic              code,
    input  logic              downstream,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] remap,
    output logic              grant,
    output logic              to_io,
    output logic              err,
    output logic [ADDR_W-1:0] addr_out
);

    logic conflict;
    logic open_eff;
    logic rights;
    logic close_hit;

    assign conflict  = ov_open && ov_close;
    assign open_eff  = ov_open && !ov_close;
    assign rights    = smm || open_eff;
    assign close_hit = ov_close && !code;

    always_comb begin
        grant    = 1'b1;
        to_io    = 1'b0;
        err      = conflict;
        addr_out = addr;
        unique case (win)
            WIN_NONE: begin
                grant = 1'b1;
            end
            WIN_COMPAT: begin
                if (downstream) begin
                    grant = 1'b0;
                    err   = 1'b1;
                end else if (rights && !close_hit) begin
                    grant = 1'b1;
                end else begin
                    grant = 1'b0;
                    to_io = 1'b1;
                end
            end
            WIN_HIGH: begin
                if (downstream) begin
                    grant = 1'b0;
                    err   = 1'b1;
                end else if (rights) begin
                    grant    = 1'b1;
                    addr_out = remap;
                end else begin
                    grant = 1'b0;
                    to_io = 1'b1;
                end
            end
            WIN_TSEG: begin
                if (downstream) begin
                    grant = 1'b0;
                    err   = 1'b1;
                end else if (rights) begin
                    grant = 1'b1;
                end else begin
                    grant = 1'b0;
                    to_io = 1'b1;
                end
            end
            default: begin
                grant = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/smm_access_ctl.sv
`timescale 1ns/1ps
module smm_access_ctl
    import smm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MB_W   = ADDR_W - MB_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTL_W-1:0]  cfg_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic [MB_W-1:0]   gfx_base_mb,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_smm,
    input  logic              req_code,
    input  logic              req_downstream,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_to_io,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_addr
);

    smm_state_e state_q;
    smm_state_e state_d;
    smm_ctl_t   ctl_s;

    // Captured request and policy snapshot
    logic [ADDR_W-1:0] addr_q;
    logic              smm_q;
    logic              code_q;
    logic              ds_q;
    logic [MB_W-1:0]   base_q;
    logic              g_en_q;
    logic              c_en_q;
    logic              h_en_q;
    logic              t_en_q;
    logic              open_q;
    logic              close_q;

    // Classification results
    smm_win_e          win_d;
    smm_win_e          win_q;
    logic [ADDR_W-1:0] remap_d;
    logic [ADDR_W-1:0] remap_q;

    // Policy results
    logic              pol_grant;
    logic              pol_io;
    logic              pol_err;
    logic [ADDR_W-1:0] pol_addr;

    smm_ctl_reg #(
        .W    (CTL_W),
        .LOCK (LOCK_POS)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .ctl     (ctl_q)
    );

    assign ctl_s     = smm_ctl_t'(ctl_q);
    assign req_ready = (state_q == ST_IDLE);

    smm_window_decode #(
        .ADDR_W (ADDR_W),
        .MB_W   (MB_W)
    ) u_decode (
        .addr      (addr_q),
        .en_global (g_en_q),
        .en_compat (c_en_q),
        .en_high   (h_en_q),
        .en_tseg   (t_en_q),
        .base_mb   (base_q),
        .win       (win_d),
        .remap     (remap_d)
    );

    smm_policy #(
        .ADDR_W (ADDR_W)
    ) u_policy (
        .win        (win_q),
        .ov_open    (open_q),
        .ov_close   (close_q),
        .smm        (smm_q),
        .code       (code_q),
        .downstream (ds_q),
        .addr       (addr_q),
        .remap      (remap_q),
        .grant      (pol_grant),
        .to_io      (pol_io),
        .err        (pol_err),
        .addr_out   (pol_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_CLASSIFY;
            ST_CLASSIFY: state_d = ST_RESPOND;
            ST_RESPOND:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath registers steered by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            smm_q   <= 1'b0;
            code_q  <= 1'b0;
            ds_q    <= 1'b0;
            base_q  <= '0;
            g_en_q  <= 1'b0;
            c_en_q  <= 1'b0;
            h_en_q  <= 1'b0;
            t_en_q  <= 1'b0;
            open_q  <= 1'b0;
            close_q <= 1'b0;
            win_q   <= WIN_NONE;
            remap_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                smm_q   <= req_smm;
                code_q  <= req_code;
                ds_q    <= req_downstream;
                base_q  <= gfx_base_mb;
                g_en_q  <= ctl_s.global_en;
                c_en_q  <= ctl_s.compat_en;
                h_en_q  <= ctl_s.high_en;
                t_en_q  <= ctl_s.tseg_en;
                open_q  <= ctl_s.open_d;
                close_q <= ctl_s.close_d;
            end
            if (state_q == ST_CLASSIFY) begin
                win_q   <= win_d;
                remap_q <= remap_d;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_to_io <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_addr  <= '0;
        end else if (state_q == ST_RESPOND) begin
            rsp_valid <= 1'b1;
            rsp_grant <= pol_grant;
            rsp_to_io <= pol_io;
            rsp_err   <= pol_err;
            rsp_addr  <= pol_addr;
        end else begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_to_io <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_addr  <= '0;
        end
    end

endmodule

// File: rtl/smm_access_ctl_chk.sv
`timescale 1ns/1ps
module smm_access_ctl_chk
    import smm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CTL_W-1:0] ctl_q,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic             rsp_to_io,
    input logic             rsp_err
);

    // R2: outputs quiet outside a response
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_grant || rsp_to_io || rsp_err));

    // R2: response lasts one cycle
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: acceptance makes the block busy
    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: block ready again as the response appears
    p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R5: I/O routing excludes a grant
    p_io_nogrant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_to_io) |-> !rsp_grant);

    // R12: locked control word does not change
    p_lock_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[LOCK_POS] |=> $stable(ctl_q));

endmodule

bind smm_access_ctl smm_access_ctl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_q     (ctl_q),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_to_io (rsp_to_io),
    .rsp_err   (rsp_err)
);

// File: tb/smm_access_ctl_tb_top.sv
`timescale 1ns/1ps
module smm_access_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic [6:0]  ctl_q;
    logic [11:0] gfx_base_mb = 12'h080;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_smm = 1'b0;
    logic        req_code = 1'b0;
    logic        req_downstream = 1'b0;
    logic        rsp_valid;
    logic        rsp_grant;
    logic        rsp_to_io;
    logic        rsp_err;
    logic [31:0] rsp_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    smm_access_ctl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_wdata      (cfg_wdata),
        .ctl_q          (ctl_q),
        .gfx_base_mb    (gfx_base_mb),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_smm        (req_smm),
        .req_code       (req_code),
        .req_downstream (req_downstream),
        .rsp_valid      (rsp_valid),
        .rsp_grant      (rsp_grant),
        .rsp_to_io      (rsp_to_io),
        .rsp_err        (rsp_err),
        .rsp_addr       (rsp_addr)
    );

    typedef struct packed {
        logic [7:0]  rid;
        logic [6:0]  ctl;
        logic        smm;
        logic        code;
        logic        ds;
        logic [11:0] base;
        logic [31:0] addr;
        logic        g;
        logic        io;
        logic        err;
        logic [31:0] eaddr;
    } vec_t;

    localparam int NV = 24;
    // ctl bits: 0 global, 1 compat, 2 high, 3 segment, 4 open, 5 close, 6 lock
    localparam vec_t VEC [NV] = '{
        '{8'd3,  7'h00, 1'b0, 1'b0, 1'b0, 12'h080, 32'h000A_1234, 1'b1, 1'b0, 1'b0, 32'h000A_1234}, // R3
        '{8'd3,  7'h00, 1'b0, 1'b0, 1'b1, 12'h080, 32'hFEDA_0010, 1'b1, 1'b0, 1'b0, 32'hFEDA_0010}, // R3
        '{8'd4,  7'h03, 1'b1, 1'b0, 1'b0, 12'h080, 32'h000A_1234, 1'b1, 1'b0, 1'b0, 32'h000A_1234}, // R4
        '{8'd5,  7'h03, 1'b0, 1'b0, 1'b0, 12'h080, 32'h000B_0000, 1'b0, 1'b1, 1'b0, 32'h000B_0000}, // R5
        '{8'd6,  7'h13, 1'b0, 1'b0, 1'b0, 12'h080, 32'h000B_FFFF, 1'b1, 1'b0, 1'b0, 32'h000B_FFFF}, // R6
        '{8'd6,  7'h1D, 1'b0, 1'b0, 1'b0, 12'h080, 32'h07F0_0040, 1'b1, 1'b0, 1'b0, 32'h07F0_0040}, // R6
        '{8'd7,  7'h23, 1'b1, 1'b0, 1'b0, 12'h080, 32'h000A_0000, 1'b0, 1'b1, 1'b0, 32'h000A_0000}, // R7
        '{8'd7,  7'h23, 1'b1, 1'b1, 1'b0, 12'h080, 32'h000A_0000, 1'b1, 1'b0, 1'b0, 32'h000A_0000}, // R7
        '{8'd7,  7'h29, 1'b1, 1'b0, 1'b0, 12'h080, 32'h07F0_0000, 1'b1, 1'b0, 1'b0, 32'h07F0_0000}, // R7
        '{8'd7,  7'h25, 1'b1, 1'b0, 1'b0, 12'h080, 32'hFEDA_0100, 1'b1, 1'b0, 1'b0, 32'h000A_0100}, // R7
        '{8'd8,  7'h33, 1'b0, 1'b0, 1'b0, 12'h080, 32'h000A_0000, 1'b0, 1'b1, 1'b1, 32'h000A_0000}, // R8
        '{8'd8,  7'h33, 1'b1, 1'b1, 1'b0, 12'h080, 32'h000A_0004, 1'b1, 1'b0, 1'b1, 32'h000A_0004}, // R8
        '{8'd9,  7'h03, 1'b1, 1'b0, 1'b1, 12'h080, 32'h000A_0000, 1'b0, 1'b0, 1'b1, 32'h000A_0000}, // R9
        '{8'd9,  7'h09, 1'b1, 1'b0, 1'b1, 12'h080, 32'h07F0_0010, 1'b0, 1'b0, 1'b1, 32'h07F0_0010}, // R9
        '{8'd10, 7'h05, 1'b1, 1'b0, 1'b0, 12'h080, 32'hFEDA_0010, 1'b1, 1'b0, 1'b0, 32'h000A_0010}, // R10
        '{8'd10, 7'h05, 1'b1, 1'b0, 1'b0, 12'h080, 32'hFEDB_FFFC, 1'b1, 1'b0, 1'b0, 32'h000B_FFFC}, // R10
        '{8'd10, 7'h05, 1'b0, 1'b0, 1'b0, 12'h080, 32'hFEDB_0000, 1'b0, 1'b1, 1'b0, 32'hFEDB_0000}, // R10
        '{8'd10, 7'h01, 1'b1, 1'b0, 1'b0, 12'h080, 32'hFEDA_0010, 1'b1, 1'b0, 1'b0, 32'hFEDA_0010}, // R10
        '{8'd11, 7'h09, 1'b0, 1'b0, 1'b0, 12'h080, 32'h07F0_0000, 1'b0, 1'b1, 1'b0, 32'h07F0_0000}, // R11
        '{8'd11, 7'h09, 1'b1, 1'b0, 1'b0, 12'h080, 32'h07FF_FFFC, 1'b1, 1'b0, 1'b0, 32'h07FF_FFFC}, // R11
        '{8'd11, 7'h09, 1'b0, 1'b0, 1'b0, 12'h080, 32'h0800_0000, 1'b1, 1'b0, 1'b0, 32'h0800_0000}, // R11
        '{8'd11, 7'h09, 1'b0, 1'b0, 1'b0, 12'h000, 32'hFFF0_0000, 1'b1, 1'b0, 1'b0, 32'hFFF0_0000}, // R11
        '{8'd13, 7'h0F, 1'b0, 1'b0, 1'b1, 12'h080, 32'h000C_0000, 1'b1, 1'b0, 1'b0, 32'h000C_0000}, // R13
        '{8'd13, 7'h0F, 1'b0, 1'b0, 1'b0, 12'h080, 32'h0009_FFFC, 1'b1, 1'b0, 1'b0, 32'h0009_FFFC}  // R13
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [6:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Returns at the negedge where the response is visible
    task automatic issue(input logic [31:0] a, input logic s, input logic c, input logic d);
        @(negedge clk);
        req_addr       = a;
        req_smm        = s;
        req_code       = c;
        req_downstream = d;
        req_valid      = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 ctl_q", 32'(ctl_q), 32'h0);
        check("R1 req_ready", 32'(req_ready), 32'h1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].rid, i);
            gfx_base_mb = VEC[i].base;
            write_ctl(VEC[i].ctl);
            issue(VEC[i].addr, VEC[i].smm, VEC[i].code, VEC[i].ds);
            check({tag, " valid"}, 32'(rsp_valid), 32'h1);
            check({tag, " grant"}, 32'(rsp_grant), 32'(VEC[i].g));
            check({tag, " to_io"}, 32'(rsp_to_io), 32'(VEC[i].io));
            check({tag, " err"},   32'(rsp_err),   32'(VEC[i].err));
            check({tag, " addr"},  rsp_addr,       VEC[i].eaddr);
        end
        gfx_base_mb = 12'h080;

        // R2: cycle-by-cycle timing
        write_ctl(7'h03);
        @(negedge clk);
        req_addr  = 32'h000A_0000;
        req_smm   = 1'b1;
        req_code  = 1'b0;
        req_downstream = 1'b0;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 busy after accept", 32'(req_ready), 32'h0);
        check("R2 no early response", 32'(rsp_valid), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R2 still busy", 32'(req_ready), 32'h0);
        check("R2 no response yet", 32'(rsp_valid), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R2 response", 32'(rsp_valid), 32'h1);
        check("R2 ready with response", 32'(req_ready), 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R2 one cycle wide", 32'(rsp_valid), 32'h0);
        check("R2 grant cleared", 32'(rsp_grant), 32'h0);

        // R12: lock freezes the control word
        write_ctl(7'h43);
        check("R12 lock written", 32'(ctl_q), 32'h43);
        write_ctl(7'h00);
        check("R12 write ignored", 32'(ctl_q), 32'h43);
        write_ctl(7'h13);
        check("R12 open write ignored", 32'(ctl_q), 32'h43);
        issue(32'h000A_0040, 1'b0, 1'b0, 1'b0);
        check("R12 frozen policy route", 32'(rsp_to_io), 32'h1);
        check("R12 frozen policy grant", 32'(rsp_grant), 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R12 cleared by reset", 32'(ctl_q), 32'h0);
        write_ctl(7'h05);
        check("R12 writable after reset", 32'(ctl_q), 32'h05);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule